// File: doc/BRIEF.md
# Pin controller with per-line interrupt triggers

This block is a memory-mapped general-purpose pin controller. A narrow register bus reaches it: a 16-bit write strobe, a halfword index and combinational read data. It drives and samples `NUM_PINS` pins. Every pin has a 2-bit mode field that sets its direction and chooses between plain pin use and the alternate function. Software writes output values through data registers. A read of the same registers returns the driven value on output pins and the synchronised input value on input pins.

The lowest `NUM_IRQ` pins are interrupt lines. Each line has a 2-bit trigger type: low level, high level, rising edge or falling edge. Its detector is fed from a two-flop synchroniser. When the trigger condition is met, the detector sets a sticky status bit, and software clears it by writing ones. Each status bit is gated by a mask bit and an enable bit. The gated bits are ORed and registered onto a single request line.

Top module: `gpio_trig_unit`

## Requirements
- R1: When reset is low, every register is zero: data, mode, trigger type, status, mask and enable. `pin_oe`, `pin_out`, `pin_alt` and `irq` are all zero.
- R2: Index 0 reads pins 0-15 and index 1 reads pins 16-31. Each bit returns the driven value if its pin is an output, and the synchronised input value if its pin is an input.
- R3: A write to a data register changes only the stored output bits of pins that are outputs at that moment. The stored bits of input pins keep their value. `pin_out` shows all stored bits.
- R4: Indices 2 to 5 are the mode registers, and each covers 8 pins (index 2 holds pins 0-7). A pin's field sits at bit 2*(pin mod 8). Field bit 0 set to 1 makes the pin an output (`pin_oe`). Field bit 1 set to 1 selects the alternate function (`pin_alt`). `pin_oe` changes only on a bus write.
- R5: Pins 8-15 take their trigger fields from index 6 and pins 0-7 from index 7. Each field sits at bit 2*(pin mod 8). The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R6: A pin change reaches the data read value after two clock edges, through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier.
- R7: An edge trigger sets the line's status bit once per matching edge. The opposite edge never sets it.
- R8: A level trigger sets the status bit on every cycle the active level is present. A clear written during that time has no lasting effect. Once the level is gone, a clear sticks.
- R9: Index 8 is the status register. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Index 9 is the mask and index 10 is the enable, with 1 meaning pass. `irq` is a registered OR over all lines of status AND mask AND enable, so it follows one cycle after its inputs.
- R11: A status bit is set whatever its mask and enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Halfword register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the indexed register (combinational) |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Stored output values |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_alt | output | NUM_PINS | Alternate-function select per pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default values: 32 pins, 16 interrupt lines and a 4-bit index. These values bring both data halves and all four mode groups within reach, including the topmost group, which holds pin 31. They also reach both halves of the swapped trigger-type register. A table of trigger cases covers every trigger code on lines in both halves, and directed tests cover level clears, synchroniser delay and the mask and enable gating of the request.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_o      <= '0;
        end else begin
            stage1_q <= d_i;
            q_o      <= stage1_q;
        end
    end
endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import gpio_trig_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  trig_t trig_i,
    input  logic  clr_i,
    output logic  stat_o
);
    logic prev_q;
    logic hit;

    always_comb begin
        unique case (trig_i)
            TRIG_LOW:  hit = !sync_i;
            TRIG_HIGH: hit = sync_i;
            TRIG_RISE: hit = sync_i && !prev_q;
            TRIG_FALL: hit = !sync_i && prev_q;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat_o <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (hit)        stat_o <= 1'b1;
            else if (clr_i) stat_o <= 1'b0;
        end
    end

    // R8: a detected condition always leaves the status set, clear or not
    assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> stat_o);
    // R9: a clear with no competing detection sticks
    assert_clear_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !stat_o);
    // R7: status never rises without a detection
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o && !hit) |=> !stat_o);
endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit
    import gpio_trig_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int NUM_IRQ  = 16,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_alt,
    output logic                irq
);
    localparam int REG_W       = 16;
    localparam int FLD_W       = 2;
    localparam int GRP         = REG_W / FLD_W;
    localparam int N_DATA      = NUM_PINS / REG_W;
    localparam int N_MODE      = NUM_PINS / GRP;
    localparam int IDX_DATA0   = 0;
    localparam int IDX_MODE0   = IDX_DATA0 + N_DATA;
    localparam int IDX_TYPE_HI = IDX_MODE0 + N_MODE;
    localparam int IDX_TYPE_LO = IDX_TYPE_HI + 1;
    localparam int IDX_STAT    = IDX_TYPE_LO + 1;
    localparam int IDX_MASK    = IDX_STAT + 1;
    localparam int IDX_EN      = IDX_MASK + 1;

    logic [NUM_PINS-1:0]           out_q;
    logic [N_MODE-1:0][REG_W-1:0]  mode_q;
    logic [1:0][REG_W-1:0]         type_q;   // [0]: lines 8-15, [1]: lines 0-7
    logic [NUM_IRQ-1:0]            mask_q;
    logic [NUM_IRQ-1:0]            en_q;
    logic [NUM_IRQ-1:0]            stat;
    logic [NUM_IRQ-1:0]            clr;
    logic [NUM_PINS-1:0]           pin_s;
    logic [NUM_PINS-1:0]           dir;
    logic [NUM_PINS-1:0]           alt;
    logic [NUM_PINS-1:0]           rd_pins;

    pin_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pin_s)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pinmode
        assign dir[p] = mode_q[p / GRP][FLD_W * (p % GRP)];
        assign alt[p] = mode_q[p / GRP][FLD_W * (p % GRP) + 1];
    end

    assign rd_pins = (out_q & dir) | (pin_s & ~dir);
    assign pin_out = out_q;
    assign pin_oe  = dir;
    assign pin_alt = alt;

    assign clr = (bus_we && bus_addr == ADDR_W'(IDX_STAT)) ? bus_wdata[NUM_IRQ-1:0] : '0;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int HALF = (i < GRP) ? 1 : 0;
        localparam int OFS  = FLD_W * (i % GRP);
        trig_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (pin_s[i]),
            .trig_i (trig_t'(type_q[HALF][OFS +: FLD_W])),
            .clr_i  (clr[i]),
            .stat_o (stat[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            mode_q <= '0;
            type_q <= '0;
            mask_q <= '0;
            en_q   <= '0;
        end else if (bus_we) begin
            for (int k = 0; k < N_DATA; k++) begin
                if (bus_addr == ADDR_W'(IDX_DATA0 + k))
                    out_q[k*REG_W +: REG_W] <= (out_q[k*REG_W +: REG_W] & ~dir[k*REG_W +: REG_W])
                                             | (bus_wdata & dir[k*REG_W +: REG_W]);
            end
            for (int k = 0; k < N_MODE; k++) begin
                if (bus_addr == ADDR_W'(IDX_MODE0 + k))
                    mode_q[k] <= bus_wdata;
            end
            if (bus_addr == ADDR_W'(IDX_TYPE_HI)) type_q[0] <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_TYPE_LO)) type_q[1] <= bus_wdata;
            if (bus_addr == ADDR_W'(IDX_MASK))    mask_q    <= bus_wdata[NUM_IRQ-1:0];
            if (bus_addr == ADDR_W'(IDX_EN))      en_q      <= bus_wdata[NUM_IRQ-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat & mask_q & en_q);
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_DATA; k++)
            if (bus_addr == ADDR_W'(IDX_DATA0 + k)) bus_rdata = rd_pins[k*REG_W +: REG_W];
        for (int k = 0; k < N_MODE; k++)
            if (bus_addr == ADDR_W'(IDX_MODE0 + k)) bus_rdata = mode_q[k];
        if (bus_addr == ADDR_W'(IDX_TYPE_HI)) bus_rdata = type_q[0];
        if (bus_addr == ADDR_W'(IDX_TYPE_LO)) bus_rdata = type_q[1];
        if (bus_addr == ADDR_W'(IDX_STAT))    bus_rdata = REG_W'(stat);
        if (bus_addr == ADDR_W'(IDX_MASK))    bus_rdata = REG_W'(mask_q);
        if (bus_addr == ADDR_W'(IDX_EN))      bus_rdata = REG_W'(en_q);
    end

    // R4: direction outputs move only on a bus write
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));
    // R10: a request needs some mask and some enable bit set one cycle earlier
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mask_q != '0 && en_q != '0));
    // R10: a request implies pending status one cycle earlier
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(stat != '0));
endmodule

// File: tb/tb_gpio_trig_unit.sv
module tb_gpio_trig_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_alt;
    logic        irq;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    gpio_trig_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt), .irq(irq)
    );

    // {pin[3:0], trigger code[1:0], start level, end level, expected status}
    localparam logic [8:0] TRIG_VEC [10] = '{
        {4'd3,  2'd1, 1'b0, 1'b1, 1'b1},
        {4'd3,  2'd1, 1'b1, 1'b0, 1'b1},
        {4'd5,  2'd0, 1'b1, 1'b1, 1'b0},
        {4'd5,  2'd0, 1'b1, 1'b0, 1'b1},
        {4'd9,  2'd2, 1'b0, 1'b1, 1'b1},
        {4'd9,  2'd2, 1'b1, 1'b0, 1'b0},
        {4'd12, 2'd3, 1'b1, 1'b0, 1'b1},
        {4'd12, 2'd3, 1'b0, 1'b1, 1'b0},
        {4'd15, 2'd2, 1'b0, 1'b0, 1'b0},
        {4'd0,  2'd3, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        // R1: reset state
        ticks(3);
        rd(4'd8, v);  check("R1 status", 32'(v), 32'h0);
        rd(4'd9, v);  check("R1 mask", 32'(v), 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        ticks(2);

        // R4: mode fields, direction and alternate select
        wr(4'd2, 16'h0001);
        check("R4 pin0 output", pin_oe, 32'h0000_0001);
        wr(4'd5, 16'hC000);
        check("R4 pin31 oe", pin_oe, 32'h8000_0001);
        check("R4 pin31 alt", pin_alt, 32'h8000_0000);

        // R2/R3: data registers
        pin_in = 32'h0000_00F0;
        wr(4'd0, 16'hFFFF);
        wr(4'd1, 16'hFFFF);
        ticks(2);
        rd(4'd0, v); check("R2 low read mix", 32'(v), 32'h0000_00F1);
        rd(4'd1, v); check("R2 high read", 32'(v), 32'h0000_8000);
        check("R3 only outputs stored", pin_out, 32'h8000_0001);
        wr(4'd2, 16'h0005);
        check("R3 input bit kept", pin_out, 32'h8000_0001);
        wr(4'd2, 16'h0000);
        wr(4'd5, 16'h0000);

        // R6: synchroniser delay
        pin_in[8] = 1'b1;
        @(negedge clk);
        rd(4'd0, v); check("R6 after one edge", 32'(v[8]), 32'h0);
        @(negedge clk);
        rd(4'd0, v); check("R6 after two edges", 32'(v[8]), 32'h1);
        pin_in = '0;
        ticks(4);

        // R5/R7/R8: trigger table
        for (int t = 0; t < 10; t++) begin
            int          pn;
            logic [1:0]  code;
            logic [15:0] fld;
            pn   = int'(TRIG_VEC[t][8:5]);
            code = TRIG_VEC[t][4:3];
            fld  = 16'(code) << (2 * (pn % 8));
            wr((pn < 8) ? 4'd7 : 4'd6, fld);
            pin_in[pn] = TRIG_VEC[t][2];
            ticks(5);
            wr(4'd8, 16'(1) << pn);
            ticks(2);
            pin_in[pn] = TRIG_VEC[t][1];
            ticks(5);
            rd(4'd8, v);
            check($sformatf("R5 R7 R8 table entry %0d", t), 32'(v[pn]), 32'(TRIG_VEC[t][0]));
        end

        // R8: clear while level active, then after it leaves
        wr(4'd7, 16'h0400);
        pin_in[5] = 1'b1;
        ticks(5);
        wr(4'd8, 16'h0020);
        ticks(1);
        rd(4'd8, v); check("R8 clear ignored while high", 32'(v[5]), 32'h1);
        pin_in[5] = 1'b0;
        ticks(4);
        wr(4'd8, 16'h0020);
        ticks(1);
        rd(4'd8, v); check("R8 clear sticks after level gone", 32'(v[5]), 32'h0);

        // R9/R10/R11: status, mask, enable, request
        wr(4'd6, 16'hAAAA);
        wr(4'd7, 16'hAAAA);
        ticks(3);
        wr(4'd8, 16'hFFFF);
        ticks(2);
        rd(4'd8, v); check("R9 all cleared", 32'(v), 32'h0);
        wr(4'd9, 16'h0200);
        pin_in[9] = 1'b1;
        ticks(5);
        rd(4'd8, v); check("R11 status set while disabled", 32'(v), 32'h0200);
        check("R10 no irq without enable", 32'(irq), 32'h0);
        wr(4'd10, 16'h0200);
        ticks(2);
        check("R10 irq with mask and enable", 32'(irq), 32'h1);
        wr(4'd9, 16'h0000);
        ticks(2);
        check("R10 irq blocked by mask", 32'(irq), 32'h0);
        wr(4'd9, 16'h0200);
        ticks(2);
        check("R10 irq back", 32'(irq), 32'h1);
        wr(4'd8, 16'h0000);
        ticks(1);
        rd(4'd8, v); check("R9 zero write no effect", 32'(v), 32'h0200);
        wr(4'd8, 16'h0200);
        ticks(2);
        rd(4'd8, v); check("R9 one write clears", 32'(v), 32'h0);
        check("R10 irq drops after clear", 32'(irq), 32'h0);

        finish_run();
    end
endmodule